// File: doc/BRIEF.md
# Sparse Fixed-Angle Shift-Add Vector Rotator

This block turns a signed fixed-point vector (x, y) through one angle that is fixed when the block is built. It uses no multipliers. The angle is one of π/16, 3π/16, 4π/16, 6π/16 or 7π/16. Only a small set of CORDIC micro-rotations runs for each angle, and every direction is wired in. The rotated vector is then scaled by a short signed sum of powers of two. The result is rounded and saturated to the output width. It fits as a rotation element inside a shift-add transform datapath, such as the butterflies of an eight-point cosine transform. The scale constants already include the transform's factor of one half.

Each vector arrives with a valid strobe and carries its own precision flag. When the flag is set, the finest micro-rotations are skipped, which trades a small angle error for less switching. The flag travels with its vector, so consecutive vectors can use different precisions. Results appear two clock cycles after their input, each with its own valid strobe.

Top module: `sparse_rot`

## Requirements
- R1: While `rst` is high, and after it until the first result, `out_valid` is 0 and both `out_x` and `out_y` read 0.
- R2: A micro-rotation of index i with direction s computes x' = x − s·2^-i·y and y' = y + s·2^-i·x. Right shifts are arithmetic. The input is held with 2 extra integer bits and 2 fraction bits.
- R3: The executed micro-rotations, in increasing index order, are:
  - ANGLE_K=1: i = 0, 1, 3, 10 with s = −1, +1, +1, +1.
  - ANGLE_K=3: i = 1, 3, 10, all with s = −1.
  - ANGLE_K=4: only i = 0 with s = +1.
  - ANGLE_K=6: first a quarter turn (x, y) → (y, −x), then i = 2, 3, 5, 7 with s = +1, +1, +1, −1.
  - ANGLE_K=7: i = 0, 1, 3, 10, all with s = −1.
- R4: The rotated vector is multiplied by a positive constant:
  - ANGLE_K = 1 or 7: 2^-2 + 2^-4 + 2^-10.
  - ANGLE_K = 3: 2^-1 − 2^-4 + 2^-7 − 2^-9.
  - ANGLE_K = 4: 2^-2 + 2^-4 + 2^-5 + 2^-7 + 2^-9.
  - ANGLE_K = 6: 2^-1 − 2^-6 − 2^-8.
  The sign of a component is never flipped by the scaling.
- R5: When `in_coarse` is 1, every micro-rotation with index ≥ FINE_FIRST (default 7) is skipped. That is i = 10 for ANGLE_K 1, 3 and 7, and i = 7 for ANGLE_K 6. ANGLE_K 4 gives the same result in both precisions.
- R6: The precision flag is taken with its own vector. Back-to-back vectors with different flags are each processed at their own precision.
- R7: A vector accepted while `in_valid` is 1 produces its result, with `out_valid` high for one cycle, exactly two rising edges later. Vectors may arrive on every cycle.
- R8: The final value is rounded to nearest, with ties toward +∞. It is then clamped to [−2^(OW−1), 2^(OW−1)−1].
- R9: `out_x` and `out_y` keep their last value on cycles with no new result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input vector strobe |
| in_coarse | input | 1 | 1 = skip the finest micro-rotations for this vector |
| in_x | input | W | Input x, signed |
| in_y | input | W | Input y, signed |
| out_valid | output | 1 | Result strobe |
| out_x | output | OW | Rotated and scaled x, signed |
| out_y | output | OW | Rotated and scaled y, signed |

## Verification
The bench builds five copies with W = OW = 16, one for each ANGLE_K value. This brings every iteration set, direction pattern, quarter turn and scale constant within reach of one shared vector stream that alternates precision. A sixth copy uses ANGLE_K = 7 with OW = 13. At full scale this copy reaches saturation at both ends of the range, which cannot happen when OW = W because the scaled gain stays near one half. Results are compared against an exact real-valued model of the requirements with a tolerance of 1.5 LSB. That is tight enough to expose the 10 LSB or larger shift caused by a missing or extra micro-rotation.

// File: rtl/sparse_rot_pkg.sv
package sparse_rot_pkg;

  localparam int NITER = 11;  // micro-rotation indices 0..10
  localparam int NSH   = 16;  // scale-term shift positions 0..15

  // micro-rotations executed for angle k*pi/16
  function automatic logic [NITER-1:0] iter_set(input int k);
    logic [NITER-1:0] m;
    m = '0;
    case (k)
      1, 7:    begin m[0] = 1'b1; m[1] = 1'b1; m[3] = 1'b1; m[10] = 1'b1; end
      3:       begin m[1] = 1'b1; m[3] = 1'b1; m[10] = 1'b1; end
      4:       m[0] = 1'b1;
      6:       begin m[2] = 1'b1; m[3] = 1'b1; m[5] = 1'b1; m[7] = 1'b1; end
      default: m = '0;
    endcase
    return m;
  endfunction

  // set bit = direction +1 (counter-clockwise), clear = -1
  function automatic logic [NITER-1:0] iter_ccw(input int k);
    logic [NITER-1:0] m;
    m = '0;
    case (k)
      1:       begin m[1] = 1'b1; m[3] = 1'b1; m[10] = 1'b1; end
      4:       m[0] = 1'b1;
      6:       begin m[2] = 1'b1; m[3] = 1'b1; m[5] = 1'b1; end
      default: m = '0;
    endcase
    return m;
  endfunction

  function automatic logic quarter_cw(input int k);
    return (k == 6);
  endfunction

  function automatic logic [NSH-1:0] scale_add(input int k);
    logic [NSH-1:0] m;
    m = '0;
    case (k)
      1, 7:    begin m[2] = 1'b1; m[4] = 1'b1; m[10] = 1'b1; end
      3:       begin m[1] = 1'b1; m[7] = 1'b1; end
      4:       begin m[2] = 1'b1; m[4] = 1'b1; m[5] = 1'b1; m[7] = 1'b1; m[9] = 1'b1; end
      6:       m[1] = 1'b1;
      default: m = '0;
    endcase
    return m;
  endfunction

  function automatic logic [NSH-1:0] scale_sub(input int k);
    logic [NSH-1:0] m;
    m = '0;
    case (k)
      3:       begin m[4] = 1'b1; m[9] = 1'b1; end
      6:       begin m[6] = 1'b1; m[8] = 1'b1; end
      default: m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/sparse_rot_step.sv
// One shift-add micro-rotation; passes the vector through when disabled.
module sparse_rot_step #(
  parameter int DW    = 20,
  parameter int SHIFT = 0,
  parameter bit CCW   = 1'b0
) (
  input  logic                 en,
  input  logic signed [DW-1:0] xi,
  input  logic signed [DW-1:0] yi,
  output logic signed [DW-1:0] xo,
  output logic signed [DW-1:0] yo
);
  logic signed [DW-1:0] dx, dy;

  assign dx = yi >>> SHIFT;
  assign dy = xi >>> SHIFT;

  always_comb begin
    if (!en) begin
      xo = xi;
      yo = yi;
    end else if (CCW) begin
      xo = xi - dx;
      yo = yi + dy;
    end else begin
      xo = xi + dx;
      yo = yi - dy;
    end
  end
endmodule

// File: rtl/sparse_rot_chain.sv
// Optional quarter turn followed by the sparse micro-rotation chain.
module sparse_rot_chain import sparse_rot_pkg::*; #(
  parameter int DW         = 20,
  parameter int ANGLE_K    = 7,
  parameter int FINE_FIRST = 7
) (
  input  logic                 coarse,
  input  logic signed [DW-1:0] x,
  input  logic signed [DW-1:0] y,
  output logic signed [DW-1:0] xo,
  output logic signed [DW-1:0] yo
);
  localparam logic [NITER-1:0] SET = iter_set(ANGLE_K);
  localparam logic [NITER-1:0] CCW = iter_ccw(ANGLE_K);
  localparam logic             QTR = quarter_cw(ANGLE_K);

  logic signed [DW-1:0] cx [NITER+1];
  logic signed [DW-1:0] cy [NITER+1];

  generate
    if (QTR) begin : g_quarter
      assign cx[0] = y;
      assign cy[0] = -x;
    end else begin : g_direct
      assign cx[0] = x;
      assign cy[0] = y;
    end

    for (genvar i = 0; i < NITER; i++) begin : g_it
      if (SET[i]) begin : g_on
        sparse_rot_step #(.DW(DW), .SHIFT(i), .CCW(CCW[i])) u_step (
          .en (!(coarse && (i >= FINE_FIRST))),
          .xi (cx[i]),
          .yi (cy[i]),
          .xo (cx[i+1]),
          .yo (cy[i+1])
        );
      end else begin : g_skip
        assign cx[i+1] = cx[i];
        assign cy[i+1] = cy[i];
      end
    end
  endgenerate

  assign xo = cx[NITER];
  assign yo = cy[NITER];
endmodule

// File: rtl/sparse_rot_scale.sv
// Shift-add constant multiply, round to nearest (ties up), saturate.
module sparse_rot_scale import sparse_rot_pkg::*; #(
  parameter int DW      = 20,
  parameter int FRAC_IN = 2,
  parameter int OW      = 16,
  parameter int ANGLE_K = 7,
  parameter int SF      = 12
) (
  input  logic signed [DW-1:0] v,
  output logic signed [OW-1:0] r
);
  localparam int PW = DW + SF + 1;
  localparam int RB = FRAC_IN + SF;
  localparam logic [NSH-1:0] ADD = scale_add(ANGLE_K);
  localparam logic [NSH-1:0] SUB = scale_sub(ANGLE_K);
  localparam logic signed [PW-1:0] HALF = PW'(64'sd1 <<< (RB - 1));
  localparam logic signed [PW-1:0] MAXV = PW'((64'sd1 <<< (OW - 1)) - 64'sd1);
  localparam logic signed [PW-1:0] MINV = PW'(-(64'sd1 <<< (OW - 1)));

  logic signed [PW-1:0] ext, acc, q;

  assign ext = PW'(v) <<< SF;

  always_comb begin
    acc = '0;
    for (int s = 0; s < NSH; s++) begin
      if (ADD[s])      acc = acc + (ext >>> s);
      else if (SUB[s]) acc = acc - (ext >>> s);
    end
  end

  assign q = (acc + HALF) >>> RB;

  always_comb begin
    if (q > MAXV)      r = OW'(MAXV);
    else if (q < MINV) r = OW'(MINV);
    else               r = OW'(q);
  end
endmodule

// File: rtl/sparse_rot.sv
module sparse_rot #(
  parameter int W          = 16,
  parameter int OW         = 16,
  parameter int GUARD_HI   = 2,
  parameter int GUARD_LO   = 2,
  parameter int ANGLE_K    = 7,
  parameter int FINE_FIRST = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 in_coarse,
  input  logic signed [W-1:0]  in_x,
  input  logic signed [W-1:0]  in_y,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_x,
  output logic signed [OW-1:0] out_y
);
  localparam int DW = W + GUARD_HI + GUARD_LO;

  logic signed [DW-1:0] xe, ye, rx, ry, s1_x, s1_y;
  logic signed [OW-1:0] sx, sy;
  logic                 s1_valid;

  assign xe = DW'(in_x) <<< GUARD_LO;
  assign ye = DW'(in_y) <<< GUARD_LO;

  sparse_rot_chain #(.DW(DW), .ANGLE_K(ANGLE_K), .FINE_FIRST(FINE_FIRST)) u_chain (
    .coarse (in_coarse),
    .x      (xe),
    .y      (ye),
    .xo     (rx),
    .yo     (ry)
  );

  // stage 1: rotated vector, precision already applied
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_x     <= '0;
      s1_y     <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_x <= rx;
        s1_y <= ry;
      end
    end
  end

  sparse_rot_scale #(.DW(DW), .FRAC_IN(GUARD_LO), .OW(OW), .ANGLE_K(ANGLE_K)) u_scale_x (
    .v (s1_x),
    .r (sx)
  );

  sparse_rot_scale #(.DW(DW), .FRAC_IN(GUARD_LO), .OW(OW), .ANGLE_K(ANGLE_K)) u_scale_y (
    .v (s1_y),
    .r (sy)
  );

  // stage 2: scaled, rounded, saturated result
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_x     <= '0;
      out_y     <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_x <= sx;
        out_y <= sy;
      end
    end
  end

  a_r7_stage1_from_input: assert property (@(posedge clk) disable iff (rst)
    s1_valid |-> $past(in_valid));

  a_r7_result_from_stage1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(s1_valid));

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !$past(s1_valid) |-> ($stable(out_x) && $stable(out_y)));

  a_r4_sign_kept_pos: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && !s1_x[DW-1] && !s1_y[DW-1]) |=> (!out_x[OW-1] && !out_y[OW-1]));

  a_r4_sign_kept_neg: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_x[DW-1]) |=> (out_x[OW-1] || (out_x == '0)));
endmodule

// File: tb/sparse_rot_bench.sv
module sparse_rot_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W   = 16;
  localparam int SOW = 13;
  localparam int NA  = 5;
  localparam int NV  = 12;
  localparam int KS [NA] = '{1, 3, 4, 6, 7};

  // {coarse, x, y}
  localparam logic [32:0] VEC [NV] = '{
    {1'b0,  16'sd32767,  16'sd0},
    {1'b1,  16'sd32767,  16'sd0},
    {1'b0,  16'sd0,      16'sd32767},
    {1'b1,  16'sd0,      16'sd32767},
    {1'b0, -16'sd32768, -16'sd32768},
    {1'b1, -16'sd32768, -16'sd32768},
    {1'b0,  16'sd32767,  16'sd32767},
    {1'b1, -16'sd32768,  16'sd32767},
    {1'b0,  16'sd12345, -16'sd23456},
    {1'b1,  16'sd12345, -16'sd23456},
    {1'b0, -16'sd1,      16'sd1},
    {1'b1,  16'sd0,      16'sd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_coarse = 1'b0;
  logic signed [W-1:0] in_x = '0;
  logic signed [W-1:0] in_y = '0;
  logic ov [NA];
  logic signed [W-1:0] ox [NA];
  logic signed [W-1:0] oy [NA];
  logic sat_v;
  logic signed [SOW-1:0] sat_x, sat_y;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar j = 0; j < NA; j++) begin : g_ang
    sparse_rot #(.W(W), .OW(W), .ANGLE_K(KS[j])) u_sparse_rot (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_coarse(in_coarse),
      .in_x(in_x), .in_y(in_y),
      .out_valid(ov[j]), .out_x(ox[j]), .out_y(oy[j])
    );
  end

  sparse_rot #(.W(W), .OW(SOW), .ANGLE_K(7)) u_sparse_rot_sat (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_coarse(in_coarse),
    .in_x(in_x), .in_y(in_y),
    .out_valid(sat_v), .out_x(sat_x), .out_y(sat_y)
  );

  task automatic step(inout real x, inout real y, input int i, input int s, input bit coarse);
    real d, nx, ny;
    if (coarse && i >= 7) return;
    d  = 1.0 / real'(1 << i);
    nx = x - s * d * y;
    ny = y + s * d * x;
    x = nx;
    y = ny;
  endtask

  function automatic real scale_of(input int k);
    case (k)
      1, 7: return 0.25 + 0.0625 + 1.0/1024.0;
      3:    return 0.5 - 0.0625 + 1.0/128.0 - 1.0/512.0;
      4:    return 0.25 + 0.0625 + 0.03125 + 1.0/128.0 + 1.0/512.0;
      6:    return 0.5 - 1.0/64.0 - 1.0/256.0;
      default: return 0.0;
    endcase
  endfunction

  // exact real-valued model of R2..R5
  task automatic model(input int k, input bit coarse, input int x0, input int y0,
                       output real rx, output real ry);
    real x, y, t;
    x = x0; y = y0;
    case (k)
      1: begin step(x,y,0,-1,coarse); step(x,y,1,1,coarse); step(x,y,3,1,coarse); step(x,y,10,1,coarse); end
      3: begin step(x,y,1,-1,coarse); step(x,y,3,-1,coarse); step(x,y,10,-1,coarse); end
      4: step(x,y,0,1,coarse);
      6: begin t = x; x = y; y = -t;
               step(x,y,2,1,coarse); step(x,y,3,1,coarse); step(x,y,5,1,coarse); step(x,y,7,-1,coarse); end
      7: begin step(x,y,0,-1,coarse); step(x,y,1,-1,coarse); step(x,y,3,-1,coarse); step(x,y,10,-1,coarse); end
      default: ;
    endcase
    rx = x * scale_of(k);
    ry = y * scale_of(k);
  endtask

  function automatic real clampr(input real v, input int ow);
    real hi, lo;
    hi = real'((1 << (ow-1)) - 1);
    lo = -real'(1 << (ow-1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  task automatic chk_near(input string req, input string what, input int act, input real ideal);
    real d;
    checks++;
    d = real'(act) - ideal;
    if (d < 0.0) d = -d;
    if (d > 1.5) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0f", req, what, act, ideal);
    end
  endtask

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input int v);
    in_valid  = 1'b1;
    in_coarse = VEC[v][32];
    in_x      = VEC[v][31:16];
    in_y      = VEC[v][15:0];
  endtask

  task automatic check_vec(input int v);
    real ex, ey;
    int x0, y0;
    bit cz;
    cz = VEC[v][32];
    x0 = int'($signed(VEC[v][31:16]));
    y0 = int'($signed(VEC[v][15:0]));
    for (int j = 0; j < NA; j++) begin
      model(KS[j], cz, x0, y0, ex, ey);
      chk_eq("R7", $sformatf("valid k=%0d v=%0d", KS[j], v), int'(ov[j]), 1);
      // R2 R3 R4 R5 R6: rotation, sets, scale, precision per vector
      chk_near("R3", $sformatf("x k=%0d v=%0d coarse=%0d", KS[j], v, cz), int'(ox[j]), ex);
      chk_near("R3", $sformatf("y k=%0d v=%0d coarse=%0d", KS[j], v, cz), int'(oy[j]), ey);
    end
    model(7, cz, x0, y0, ex, ey);
    chk_near("R8", $sformatf("sat x v=%0d", v), int'(sat_x), clampr(ex, SOW));
    chk_near("R8", $sformatf("sat y v=%0d", v), int'(sat_y), clampr(ey, SOW));
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    int k4x_full, k4x_coarse, hx, hy;
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int j = 0; j < NA; j++) begin
      chk_eq("R1", $sformatf("valid in reset k=%0d", KS[j]), int'(ov[j]), 0);
      chk_eq("R1", $sformatf("x in reset k=%0d", KS[j]), int'(ox[j]), 0);
      chk_eq("R1", $sformatf("y in reset k=%0d", KS[j]), int'(oy[j]), 0);
    end
    rst = 1'b0;

    // stream the table back to back; R6 alternates precision each vector
    k4x_full = 0; k4x_coarse = 0;
    for (int v = 0; v < NV + 2; v++) begin
      @(negedge clk);
      if (v < 2) chk_eq("R7", $sformatf("no early valid step=%0d", v), int'(ov[0]), 0);
      else begin
        check_vec(v - 2);
        if (v - 2 == 0) k4x_full = int'(oy[2]);
        if (v - 2 == 1) k4x_coarse = int'(oy[2]);
      end
      if (v < NV) drive(v);
      else in_valid = 1'b0;
    end
    // R5: the single-iteration angle ignores the precision flag
    chk_eq("R5", "k=4 coarse vs full", k4x_coarse, k4x_full);
    // R5: the flag must change a 7pi/16 result at full scale
    checks++;
    begin
      real a, b, c, d;
      model(7, 1'b0, 0, 32767, a, b);
      model(7, 1'b1, 0, 32767, c, d);
      if ((a - c) < 3.0 && (c - a) < 3.0) begin
        fails++;
        $display("FAIL R5 model gap actual=%0f expected=%0f", c, a);
      end
    end

    // R7: isolated vector, exact two-edge latency and single-cycle strobe
    @(negedge clk);
    drive(6);
    @(negedge clk);
    in_valid = 1'b0;
    chk_eq("R7", "one edge later", int'(ov[4]), 0);
    @(negedge clk);
    chk_eq("R7", "two edges later", int'(ov[4]), 1);
    hx = int'(ox[4]); hy = int'(oy[4]);
    @(negedge clk);
    chk_eq("R7", "strobe one cycle", int'(ov[4]), 0);

    // R9: idle inputs change, outputs hold
    in_x = 16'sd777; in_y = -16'sd999; in_coarse = 1'b1;
    repeat (4) @(negedge clk);
    chk_eq("R9", "hold x", int'(ox[4]), hx);
    chk_eq("R9", "hold y", int'(oy[4]), hy);

    // R1: reset clears a loaded pipeline
    drive(4);
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk_eq("R1", "valid after mid-run reset", int'(ov[4]), 0);
    chk_eq("R1", "x after mid-run reset", int'(ox[4]), 0);
    rst = 1'b0;
    @(negedge clk);
    chk_eq("R1", "no stale result", int'(ov[4]), 0);

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      finish_run();
    end
  end
endmodule